// File: doc/BRIEF.md
# Dual Peripheral Port With Mode Select

This block owns two independent 7-bit bidirectional peripheral ports. A host writes per-port registers through a byte-wide write interface:
- a per-bit direction register;
- a data register;
- a one-bit ownership (mode) select;
- a one-bit external-latch enable for pin 6.

The block drives output enables and output levels toward the pads. It samples the pad inputs through a synchronizer and hands them back both to the host, through data-register reads, and to an internal peripheral controller.

Ownership of each port switches between two masters. In controller mode, which is the reset state, the internal controller supplies the pin directions and output levels. In direct mode, the host's direction and data registers drive the pins. When the latch enable is set and pin 6 is an input, the synchronized pin 6 level is routed out as a latch/interrupt request.

Top module: `dual_periph_port`

## Requirements
- R1: After reset every direction, data, mode and latch-enable register is 0. Both ports are therefore in controller mode, both latch requests are low, and a data read returns the synchronized pin levels.
- R2: Register address map, with `hostAddr[0]` selecting the port and `hostAddr[2:1]` selecting the register: 00 data, 01 direction, 10 mode, 11 latch enable. Mode and latch enable take `hostWrData[0]`. In mode, 1 means direct host control and 0 means controller.
- R3: In direct mode, `pinOe` of the port equals its direction register (1 = output).
- R4: In direct mode, `pinOut` carries the data-register bit for output bits and 0 for input bits.
- R5: A data read returns, per bit, the written data-register value where the host direction bit is 1, and the synchronized pin level where it is 0.
- R6: Direction, mode and latch-enable addresses read as 0. Bit 7 of every read is 0, and bit 7 of a write has no effect.
- R7: A pin change is visible in reads and on `ctlPinIn` after exactly two rising clock edges.
- R8: In controller mode, `pinOe` equals `ctlDir`, and `pinOut` equals `ctlOut` masked by `ctlDir`. Host data and direction writes still update the registers, as seen by reads.
- R9: `latchReq` of a port is 1 only while its latch enable is 1, its effective pin 6 direction is input, and synchronized pin 6 is 1.
- R10: A write to one port's registers leaves the other port's pins and reads unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostAddr | input | 3 | Register address (port in bit 0, register in bits 2:1) |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Combinational read byte for hostAddr |
| ctlDir | input | 2x7 | Controller direction per port |
| ctlOut | input | 2x7 | Controller output levels per port |
| ctlPinIn | output | 2x7 | Synchronized pin levels for the controller |
| pinIn | input | 2x7 | Raw pad input levels |
| pinOe | output | 2x7 | Pad output enables |
| pinOut | output | 2x7 | Pad output levels |
| latchReq | output | 2 | Pin 6 latch/interrupt request per port |

## Verification
Pin patterns 55, 0F, 70 and 2A are set against direction masks 0F, 01 and 4F. A wrong per-bit merge between pin level and written value therefore shows up in different bit positions.

One pin change is sampled after one and after two edges, which separates a correct two-flop delay from a one-flop or three-flop delay. Port 1 is kept in controller mode while port 0 runs in direct mode, which tells ownership errors apart from cross-port decoding errors. The latch request is driven by toggling pin 6, then by flipping its direction, then by clearing the enable, so each of the three gating terms is shown to be needed.

// File: rtl/periph_port_pkg.sv
package periph_port_pkg;
  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned PORT_W    = 7;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned LATCH_BIT = 6;
  localparam int unsigned PSEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int unsigned ADDR_W    = PSEL_W + 2;

  typedef enum logic [1:0] {
    FLD_DATA  = 2'd0,
    FLD_DIR   = 2'd1,
    FLD_MODE  = 2'd2,
    FLD_LATCH = 2'd3
  } field_e;

  typedef struct packed {
    logic [NUM_PORTS-1:0] dataWr;
    logic [NUM_PORTS-1:0] dirWr;
    logic [NUM_PORTS-1:0] modeWr;
    logic [NUM_PORTS-1:0] latchWr;
    logic                 rdData;
    logic [PSEL_W-1:0]    rdPort;
  } strobe_t;
endpackage

// File: rtl/periph_port_sync.sv
module periph_port_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < int'(STAGES); i++) begin
        stage[i] <= stage[i-1];
      end
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/periph_port_ctrl.sv
module periph_port_ctrl
  import periph_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  output strobe_t           strobes
);
  logic [PSEL_W-1:0] portSel;
  field_e            fieldSel;
  logic              portOk;

  assign portSel  = hostAddr[PSEL_W-1:0];
  assign fieldSel = field_e'(hostAddr[ADDR_W-1:PSEL_W]);
  assign portOk   = (int'(portSel) < int'(NUM_PORTS));

  always_comb begin
    strobes = '0;
    strobes.rdPort = portSel;
    strobes.rdData = portOk && (fieldSel == FLD_DATA);
    if (hostWrEn && portOk) begin
      unique case (fieldSel)
        FLD_DATA:  strobes.dataWr[portSel]  = 1'b1;
        FLD_DIR:   strobes.dirWr[portSel]   = 1'b1;
        FLD_MODE:  strobes.modeWr[portSel]  = 1'b1;
        FLD_LATCH: strobes.latchWr[portSel] = 1'b1;
        default: ;
      endcase
    end
  end

  // R2: at most one register strobe per cycle
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.dataWr, strobes.dirWr, strobes.modeWr, strobes.latchWr}));

  // R10: no strobe without a host write
  a_r10_strobe_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    !hostWrEn |-> ({strobes.dataWr, strobes.dirWr, strobes.modeWr, strobes.latchWr} == '0));
endmodule

// File: rtl/periph_port_dp.sv
module periph_port_dp
  import periph_port_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  strobe_t                             strobes,
  input  logic [BYTE_W-1:0]                   wrByte,
  output logic [BYTE_W-1:0]                   rdByte,
  input  logic [NUM_PORTS-1:0][PORT_W-1:0]    ctlDir,
  input  logic [NUM_PORTS-1:0][PORT_W-1:0]    ctlOut,
  output logic [NUM_PORTS-1:0][PORT_W-1:0]    ctlPinIn,
  input  logic [NUM_PORTS-1:0][PORT_W-1:0]    pinIn,
  output logic [NUM_PORTS-1:0][PORT_W-1:0]    pinOe,
  output logic [NUM_PORTS-1:0][PORT_W-1:0]    pinOut,
  output logic [NUM_PORTS-1:0]                latchReq
);
  localparam int unsigned PAD_W = BYTE_W - PORT_W;

  logic [NUM_PORTS-1:0][PORT_W-1:0] readVal;
  logic [1:0] sinceRst;

  always_ff @(posedge clk) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  for (genvar p = 0; p < int'(NUM_PORTS); p++) begin : g_port
    logic [PORT_W-1:0] dirReg, dataReg, syncPin, effOe, srcOut;
    logic              modeReg, latchEn;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        dirReg  <= '0;
        dataReg <= '0;
        modeReg <= 1'b0;
        latchEn <= 1'b0;
      end else begin
        if (strobes.dirWr[p])   dirReg  <= wrByte[PORT_W-1:0];
        if (strobes.dataWr[p])  dataReg <= wrByte[PORT_W-1:0];
        if (strobes.modeWr[p])  modeReg <= wrByte[0];
        if (strobes.latchWr[p]) latchEn <= wrByte[0];
      end
    end

    periph_port_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rstN (rstN),
      .din  (pinIn[p]),
      .dout (syncPin)
    );

    assign effOe       = modeReg ? dirReg  : ctlDir[p];
    assign srcOut      = modeReg ? dataReg : ctlOut[p];
    assign pinOe[p]    = effOe;
    assign pinOut[p]   = srcOut & effOe;
    assign readVal[p]  = (dirReg & dataReg) | (~dirReg & syncPin);
    assign ctlPinIn[p] = syncPin;
    assign latchReq[p] = latchEn & ~effOe[LATCH_BIT] & syncPin[LATCH_BIT];

    // R4: an input bit never drives a level
    a_r4_no_drive_on_input: assert property (@(posedge clk) disable iff (!rstN)
      (pinOut[p] & ~pinOe[p]) == '0);

    // R9: latch request only with pin 6 as input
    a_r9_latch_needs_input: assert property (@(posedge clk) disable iff (!rstN)
      latchReq[p] |-> !pinOe[p][LATCH_BIT]);

    // R6: data register takes the low bits of the written byte
    a_r6_data_write: assert property (@(posedge clk) disable iff (!rstN)
      strobes.dataWr[p] |=> dataReg == $past(wrByte[PORT_W-1:0]));

    if (SYNC_STAGES == 2) begin : g_sync_chk
      // R7: synchronized pins lag the raw pins by two edges
      a_r7_sync_delay: assert property (@(posedge clk) disable iff (!rstN)
        (sinceRst == 2'd3) |-> ctlPinIn[p] == $past(pinIn[p], 2));
    end
  end

  always_comb begin
    rdByte = '0;
    if (strobes.rdData) rdByte = {{PAD_W{1'b0}}, readVal[strobes.rdPort]};
  end

  // R6: bit 7 of reads is always zero
  a_r6_top_bit_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdByte[BYTE_W-1] == 1'b0);
endmodule

// File: rtl/dual_periph_port.sv
module dual_periph_port
  import periph_port_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             hostWrEn,
  input  logic [ADDR_W-1:0]                hostAddr,
  input  logic [BYTE_W-1:0]                hostWrData,
  output logic [BYTE_W-1:0]                hostRdData,
  input  logic [NUM_PORTS-1:0][PORT_W-1:0] ctlDir,
  input  logic [NUM_PORTS-1:0][PORT_W-1:0] ctlOut,
  output logic [NUM_PORTS-1:0][PORT_W-1:0] ctlPinIn,
  input  logic [NUM_PORTS-1:0][PORT_W-1:0] pinIn,
  output logic [NUM_PORTS-1:0][PORT_W-1:0] pinOe,
  output logic [NUM_PORTS-1:0][PORT_W-1:0] pinOut,
  output logic [NUM_PORTS-1:0]             latchReq
);
  strobe_t strobes;

  periph_port_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostWrEn (hostWrEn),
    .hostAddr (hostAddr),
    .strobes  (strobes)
  );

  periph_port_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrByte   (hostWrData),
    .rdByte   (hostRdData),
    .ctlDir   (ctlDir),
    .ctlOut   (ctlOut),
    .ctlPinIn (ctlPinIn),
    .pinIn    (pinIn),
    .pinOe    (pinOe),
    .pinOut   (pinOut),
    .latchReq (latchReq)
  );
endmodule

// File: tb/dual_periph_port_bench.sv
module dual_periph_port_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0;
  logic [2:0] hostAddr = '0;
  logic [7:0] hostWrData = '0;
  logic [7:0] hostRdData;
  logic [1:0][6:0] ctlDir = '0, ctlOut = '0, ctlPinIn, pinIn = '0, pinOe, pinOut;
  logic [1:0] latchReq;

  int nRun = 0, nFail = 0;
  bit done = 0;

  typedef struct {
    string      req;
    int         sel;
    int         port;
    logic [7:0] exp;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  dual_periph_port u_dual_periph_port (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .ctlDir(ctlDir),
    .ctlOut(ctlOut), .ctlPinIn(ctlPinIn), .pinIn(pinIn), .pinOe(pinOe),
    .pinOut(pinOut), .latchReq(latchReq)
  );

  // sel: 0 read byte, 1 pinOe, 2 pinOut, 3 latchReq, 4 ctlPinIn
  function automatic logic [7:0] observe(int sel, int port);
    case (sel)
      0: return hostRdData;
      1: return {1'b0, pinOe[port]};
      2: return {1'b0, pinOut[port]};
      3: return {7'b0, latchReq[port]};
      default: return {1'b0, ctlPinIn[port]};
    endcase
  endfunction

  function automatic logic [7:0] mixRd(logic [6:0] dir, logic [6:0] data, logic [6:0] pins);
    return {1'b0, (dir & data) | (~dir & pins)};
  endfunction

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] got;
        it = q.pop_front();
        got = observe(it.sel, it.port);
        nRun++;
        if (got !== it.exp) begin
          nFail++;
          $display("FAIL %s sel=%0d port=%0d actual=%02h expected=%02h",
                   it.req, it.sel, it.port, got, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic expect_sig(input string req, input int sel, input int port,
                            input logic [7:0] e, input logic [2:0] a = 3'd0);
    hostAddr = a;
    q.push_back('{req, sel, port, e});
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_sig("R1", 0, 0, 8'h00, 3'd0);
    expect_sig("R1", 1, 0, 8'h00);
    expect_sig("R1", 3, 0, 8'h00);
    expect_sig("R1", 3, 1, 8'h00);

    // R7 sync timing
    pinIn[0] = 7'h55; pinIn[1] = 7'h2A;
    @(negedge clk);
    expect_sig("R7", 4, 0, 8'h00);
    expect_sig("R7", 4, 0, 8'h55);
    expect_sig("R5", 0, 0, 8'h55, 3'd0);
    pinIn[0] = 7'h0F;
    @(negedge clk);
    expect_sig("R7", 0, 0, 8'h55, 3'd0);
    expect_sig("R7", 0, 0, 8'h0F, 3'd0);

    // R2/R3/R4: direct mode on port 0
    wr(3'b100, 8'h01);
    wr(3'b010, 8'h0F);
    wr(3'b000, 8'h33);
    expect_sig("R3", 1, 0, 8'h0F);
    expect_sig("R4", 2, 0, 8'h03);
    expect_sig("R5", 0, 0, mixRd(7'h0F, 7'h33, 7'h0F), 3'd0);
    pinIn[0] = 7'h70; settle();
    expect_sig("R5", 0, 0, mixRd(7'h0F, 7'h33, 7'h70), 3'd0);

    // R6: bit 7 ignored, write-only addresses read zero
    wr(3'b000, 8'hFF);
    expect_sig("R6", 0, 0, mixRd(7'h0F, 7'h7F, 7'h70), 3'd0);
    expect_sig("R6", 0, 0, 8'h00, 3'b010);
    expect_sig("R6", 0, 0, 8'h00, 3'b100);
    expect_sig("R6", 0, 0, 8'h00, 3'b110);

    // R10: port 1 unchanged by port 0 writes
    ctlDir[1] = 7'h3C; ctlOut[1] = 7'h7F;
    @(negedge clk);
    expect_sig("R10", 1, 1, 8'h3C);
    expect_sig("R10", 0, 1, 8'h2A, 3'd1);

    // R8: controller mode on port 1, host writes still land
    wr(3'b001, 8'h11);
    wr(3'b011, 8'h01);
    expect_sig("R8", 1, 1, 8'h3C);
    expect_sig("R8", 2, 1, 8'h3C);
    expect_sig("R8", 0, 1, mixRd(7'h01, 7'h11, 7'h2A), 3'd1);
    expect_sig("R10", 2, 0, 8'h0F);

    // R9: latch request gating
    wr(3'b110, 8'h01);
    expect_sig("R9", 3, 0, 8'h01);
    expect_sig("R9", 3, 1, 8'h00);
    pinIn[0] = 7'h30; settle();
    expect_sig("R9", 3, 0, 8'h00);
    pinIn[0] = 7'h40; settle();
    expect_sig("R9", 3, 0, 8'h01);
    wr(3'b010, 8'h4F);
    expect_sig("R9", 3, 0, 8'h00);
    wr(3'b010, 8'h0F);
    expect_sig("R9", 3, 0, 8'h01);
    wr(3'b110, 8'h00);
    expect_sig("R9", 3, 0, 8'h00);

    // R2: back to controller mode on port 0
    ctlDir[0] = 7'h12; ctlOut[0] = 7'h7F;
    wr(3'b100, 8'h00);
    expect_sig("R2", 1, 0, 8'h12);
    expect_sig("R8", 2, 0, 8'h12);

    @(negedge clk);
    #2;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule